// File: doc/BRIEF.md
# Card Data Transmit Ping-Pong Buffer

This block sends data blocks to a memory card over a single data line. The host writes payload bytes into a pair of 8-byte FIFOs. The FIFOs fill in alternation: the first, then the second, then the first again. The serializer drains them in the same alternation. Each FIFO has its own empty flag, so software can refill one half while the other half is being shifted out. Each empty flag can raise an interrupt request, and each has its own mask bit; with the mask set, software polls the flag instead.

Before a transfer, software fills both halves with 16 bytes in total and then raises the run control. Each frame on the line has this form:
- a low start bit;
- the block's payload bytes, most significant bit first;
- a 16-bit CRC (polynomial 0x1021, seed zero), most significant bit first;
- a high end bit.

The number of payload bytes per frame comes from a length input. Frames follow one another while run stays high and data is ready. If a half runs dry in the middle of a block, the line idles high until the next half is full, and a sticky underrun bit records the event. A write that finds no half able to take it is dropped and sets a sticky overflow bit. A direction input enables the block only for transmit.

Top module: `card_tx_pingpong`

## Requirements
- R1: After reset, both empty flags read 1, the line reads 1, the output enable reads 0, and both status bits read 0.
- R2: Accepted writes fill FIFO A (flag `empty_a`) first with 8 bytes, then FIFO B with 8 bytes, then alternate. A half takes writes only after it has fully drained.
- R3: A write arriving while the half it would go to is still full is discarded, and `overflow` reads 1 from the next cycle on. The bytes sent on the line are unchanged by the discarded write.
- R4: A frame drives `dat_oe` high for its full length and sends these bits in order:
  - start bit 0;
  - each payload byte MSB first;
  - the CRC, MSB first: a CRC16 with polynomial x^16+x^12+x^5+1 and seed 0, over the payload bits only;
  - end bit 1.
  With `dat_oe` low, the line reads 1.
- R5: A frame carries `blk_len` payload bytes, sampled when the frame starts. A length of 0 sends one byte. An unstalled frame lasts 8*L+18 cycles.
- R6: Bytes leave in the order they were written, taken from A and B in alternation. A half's empty flag rises the cycle after its last byte is taken.
- R7: `irq` equals (`empty_a` AND NOT `mask_a`) OR (`empty_b` AND NOT `mask_b`) while transmit is selected.
- R8: If no full half is ready at a byte boundary inside a block:
  - the line holds 1 with `dat_oe` still 1;
  - `underrun` becomes 1 and stays set;
  - the frame resumes with the next byte once a half is full.
- R9: A frame starts only while `run_en` is 1 and a full half is ready. Lowering `run_en` lets the frame in progress finish and starts no further frame.
- R10: While `xmit_sel` is 0:
  - writes are ignored and the FIFO contents are kept;
  - the line is idle, with `dat_oe` at 0;
  - `irq` reads 0;
  - both status bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xmit_sel | input | 1 | 1 selects transmit; 0 idles the block |
| run_en | input | 1 | Allows new frames to start |
| blk_len | input | LEN_W | Payload bytes per frame (0 acts as 1) |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DW | Byte to write |
| mask_a | input | 1 | Masks the FIFO A empty interrupt |
| mask_b | input | 1 | Masks the FIFO B empty interrupt |
| dat_out | output | 1 | Serial data line |
| dat_oe | output | 1 | High while a frame occupies the line |
| empty_a | output | 1 | FIFO A holds no bytes |
| empty_b | output | 1 | FIFO B holds no bytes |
| irq | output | 1 | Interrupt request from unmasked empty flags |
| underrun | output | 1 | Sticky: a block stalled for lack of data |
| overflow | output | 1 | Sticky: a write was discarded |

## Verification
The main sequence is a 9-byte block of the ASCII digits 1 to 9. Its CRC must come out as the well-known value 0x31C3, which separates a correct polynomial, seed and bit order from near variants. A one-byte frame with a zero length setting, and a run of 4-byte frames fed by alternate refills, separate correct length sampling and correct half swapping from off-by-one counting. A deliberate starvation and a seventeenth prefill byte exercise the stall and the discard paths. A reference model of the queues is compared with every output on every cycle.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STALL,
    S_CRC,
    S_END
  } ser_state_e;

  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // One bit of the serial CRC: feedback is the top bit XOR the data bit.
  function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  // A zero length field means one byte.
  function automatic int unsigned eff_len(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

endpackage

// File: rtl/ctx_fifo_pair.sv
module ctx_fifo_pair #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          avail,
  output logic [1:0]    empty,
  output logic          wr_rej
);
  localparam int            CW      = $clog2(DEPTH + 1);
  localparam int            IW      = $clog2(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          wsel_q, rsel_q;
  logic [CW-1:0] cnt_w  [2];
  logic [1:0]    rdy_w;
  logic [DW-1:0] dout_w [2];
  logic          wr_acc, pop_ok;

  assign wr_acc  = enable & wr_en & ~rdy_w[wsel_q];
  assign wr_rej  = enable & wr_en &  rdy_w[wsel_q];
  assign avail   = rdy_w[rsel_q];
  assign pop_ok  = pop & avail;
  assign rd_data = dout_w[rsel_q];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BID = 1'(b);
    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          rdy_q;
    logic          wr_here, rd_here;

    assign wr_here = wr_acc & (wsel_q == BID);
    assign rd_here = pop_ok & (rsel_q == BID);

    always_ff @(posedge clk) begin
      if (wr_here) mem_q[cnt_q[IW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        rdy_q <= 1'b0;
      end else if (wr_here) begin
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == DEPTH_C - CW'(1)) rdy_q <= 1'b1;
      end else if (rd_here) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) rdy_q <= 1'b0;
      end
    end

    assign cnt_w[b]  = cnt_q;
    assign rdy_w[b]  = rdy_q;
    assign dout_w[b] = mem_q[IW'(DEPTH_C - cnt_q)];
    assign empty[b]  = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      if (wr_acc && cnt_w[wsel_q] == DEPTH_C - CW'(1)) wsel_q <= ~wsel_q;
      if (pop_ok && cnt_w[rsel_q] == CW'(1))           rsel_q <= ~rsel_q;
    end
  end

endmodule

// File: rtl/ctx_serializer.sv
module ctx_serializer
  import ctx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             avail,
  input  logic [DW-1:0]    byte_in,
  output logic             pop,
  output logic             dat_out,
  output logic             dat_oe,
  output logic             stall_evt
);
  localparam int BC_W = $clog2(CRC_W);

  ser_state_e       st_q;
  logic [DW-1:0]    sh_q;
  logic [BC_W-1:0]  bitc_q;
  logic [LEN_W-1:0] left_q;
  logic [15:0]      crc_q;
  logic             byte_end, last_byte, start_ok;

  assign byte_end  = (st_q == S_DATA) && (bitc_q == BC_W'(DW - 1));
  assign last_byte = (left_q <= LEN_W'(1));
  assign start_ok  = (st_q == S_IDLE) && run && avail;

  assign pop = enable & (start_ok
                        | (byte_end && !last_byte && avail)
                        | ((st_q == S_STALL) && avail));
  assign stall_evt = enable & byte_end & ~last_byte & ~avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      bitc_q <= '0;
      left_q <= '0;
      crc_q  <= '0;
    end else if (!enable) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (start_ok) begin
          sh_q   <= byte_in;
          left_q <= LEN_W'(eff_len(int'(blk_len)));
          crc_q  <= '0;
          bitc_q <= '0;
          st_q   <= S_START;
        end
        S_START: st_q <= S_DATA;
        S_DATA: begin
          crc_q <= crc16_bit(crc_q, sh_q[DW-1]);
          sh_q  <= {sh_q[DW-2:0], 1'b0};
          if (byte_end) begin
            bitc_q <= '0;
            if (last_byte) begin
              st_q <= S_CRC;
            end else begin
              left_q <= left_q - LEN_W'(1);
              if (avail) sh_q <= byte_in;
              else       st_q <= S_STALL;
            end
          end else begin
            bitc_q <= bitc_q + BC_W'(1);
          end
        end
        S_STALL: if (avail) begin
          sh_q <= byte_in;
          st_q <= S_DATA;
        end
        S_CRC: begin
          crc_q <= {crc_q[14:0], 1'b0};
          if (bitc_q == BC_W'(CRC_W - 1)) begin
            bitc_q <= '0;
            st_q   <= S_END;
          end else begin
            bitc_q <= bitc_q + BC_W'(1);
          end
        end
        S_END:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_START: dat_out = 1'b0;
      S_DATA:  dat_out = sh_q[DW-1];
      S_CRC:   dat_out = crc_q[15];
      default: dat_out = 1'b1;
    endcase
  end

  assign dat_oe = (st_q != S_IDLE);

endmodule

// File: rtl/ctx_status.sv
module ctx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wr_rej,
  input  logic       stall_evt,
  input  logic [1:0] empty,
  input  logic [1:0] mask,
  output logic       underrun,
  output logic       overflow,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else if (!enable) begin
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (stall_evt) underrun <= 1'b1;
      if (wr_rej)    overflow <= 1'b1;
    end
  end

  assign irq = enable & |(empty & ~mask);

endmodule

// File: rtl/card_tx_pingpong.sv
module card_tx_pingpong #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xmit_sel,
  input  logic             run_en,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             mask_a,
  input  logic             mask_b,
  output logic             dat_out,
  output logic             dat_oe,
  output logic             empty_a,
  output logic             empty_b,
  output logic             irq,
  output logic             underrun,
  output logic             overflow
);
  logic          pop_evt, wr_rej, stall_evt, avail;
  logic [DW-1:0] rd_byte;
  logic [1:0]    empty_v;

  ctx_fifo_pair #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .enable(xmit_sel),
    .wr_en(wr_en), .wr_data(wr_data),
    .pop(pop_evt), .rd_data(rd_byte), .avail(avail),
    .empty(empty_v), .wr_rej(wr_rej)
  );

  ctx_serializer #(.DW(DW), .LEN_W(LEN_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .enable(xmit_sel), .run(run_en),
    .blk_len(blk_len), .avail(avail), .byte_in(rd_byte),
    .pop(pop_evt), .dat_out(dat_out), .dat_oe(dat_oe),
    .stall_evt(stall_evt)
  );

  ctx_status u_stat (
    .clk(clk), .rst_n(rst_n), .enable(xmit_sel),
    .wr_rej(wr_rej), .stall_evt(stall_evt),
    .empty(empty_v), .mask({mask_b, mask_a}),
    .underrun(underrun), .overflow(overflow), .irq(irq)
  );

  assign empty_a = empty_v[0];
  assign empty_b = empty_v[1];

endmodule

// File: rtl/ctx_checker.sv
module ctx_checker (
  input logic clk,
  input logic rst_n,
  input logic xmit_sel,
  input logic run_en,
  input logic mask_a,
  input logic mask_b,
  input logic dat_out,
  input logic dat_oe,
  input logic empty_a,
  input logic empty_b,
  input logic irq,
  input logic underrun,
  input logic overflow,
  input logic pop_evt,
  input logic wr_rej,
  input logic stall_evt
);
  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_oe |-> dat_out);

  p_start_bit_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> !dat_out);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rej && xmit_sel) |=> overflow);

  p_stall_holds_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_evt && xmit_sel) |=> (dat_oe && dat_out && underrun));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((empty_a && !mask_a) || (empty_b && !mask_b)));

  p_rx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_sel |=> (!dat_oe && !underrun && !overflow));

  p_rx_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !xmit_sel |-> !irq);

  p_pop_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> !(empty_a && empty_b));

  p_start_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> $past(run_en));
endmodule

bind card_tx_pingpong ctx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .xmit_sel(xmit_sel), .run_en(run_en),
  .mask_a(mask_a), .mask_b(mask_b), .dat_out(dat_out), .dat_oe(dat_oe),
  .empty_a(empty_a), .empty_b(empty_b), .irq(irq),
  .underrun(underrun), .overflow(overflow),
  .pop_evt(pop_evt), .wr_rej(wr_rej), .stall_evt(stall_evt)
);

// File: tb/tb_card_tx_pingpong.sv
module tb_card_tx_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xmit_sel = 1'b0, run_en = 1'b0, wr_en = 1'b0;
  logic mask_a = 1'b0, mask_b = 1'b0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [7:0] wr_data = '0;
  logic dat_out, dat_oe, empty_a, empty_b, irq, underrun, overflow;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_tx_pingpong #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .xmit_sel(xmit_sel), .run_en(run_en),
    .blk_len(blk_len), .wr_en(wr_en), .wr_data(wr_data),
    .mask_a(mask_a), .mask_b(mask_b), .dat_out(dat_out), .dat_oe(dat_oe),
    .empty_a(empty_a), .empty_b(empty_b), .irq(irq),
    .underrun(underrun), .overflow(overflow)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: two byte queues, a phase number and integer counters.
  logic [7:0] q0[$], q1[$];
  bit   m_full[2];
  int   m_ws, m_rs, m_ph, m_bit, m_left;
  logic [7:0]  m_sh;
  logic [15:0] m_crc;
  bit   m_und, m_ovf;

  function automatic logic [15:0] crc_next(logic [15:0] c, logic b);
    int v;
    v = (int'(c) * 2) % 65536;
    if ((c >> 15) != 16'(b)) v = v ^ 'h1021;
    return 16'(v);
  endfunction

  function automatic int qsize(int k);
    return (k == 0) ? q0.size() : q1.size();
  endfunction

  function automatic logic [7:0] take();
    logic [7:0] v;
    if (m_rs == 0) v = q0.pop_front(); else v = q1.pop_front();
    if (qsize(m_rs) == 0) begin m_full[m_rs] = 0; m_rs = 1 - m_rs; end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0.delete(); q1.delete(); m_full[0] = 0; m_full[1] = 0;
      m_ws = 0; m_rs = 0; m_ph = 0; m_bit = 0; m_left = 0;
      m_sh = 0; m_crc = 0; m_und = 0; m_ovf = 0;
    end else if (!xmit_sel) begin
      m_ph = 0; m_und = 0; m_ovf = 0;
    end else begin
      bit av;
      av = m_full[m_rs];
      if (wr_en) begin
        if (m_full[m_ws]) m_ovf = 1;
        else begin
          if (m_ws == 0) q0.push_back(wr_data); else q1.push_back(wr_data);
          if (qsize(m_ws) == 8) begin m_full[m_ws] = 1; m_ws = 1 - m_ws; end
        end
      end
      case (m_ph)
        0: if (run_en && av) begin
             m_sh = take(); m_left = (blk_len == 0) ? 1 : int'(blk_len);
             m_crc = 0; m_bit = 0; m_ph = 1;
           end
        1: m_ph = 2;
        2: begin
             m_crc = crc_next(m_crc, m_sh[7]);
             m_sh = m_sh << 1;
             if (m_bit == 7) begin
               m_bit = 0;
               if (m_left <= 1) m_ph = 4;
               else begin
                 m_left--;
                 if (av) m_sh = take();
                 else begin m_ph = 3; m_und = 1; end
               end
             end else m_bit++;
           end
        3: if (av) begin m_sh = take(); m_ph = 2; end
        4: begin
             m_crc = m_crc << 1;
             if (m_bit == 15) begin m_bit = 0; m_ph = 5; end else m_bit++;
           end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic e_line, ea, eb;
      e_line = (m_ph == 1) ? 1'b0 : (m_ph == 2) ? m_sh[7] : (m_ph == 4) ? m_crc[15] : 1'b1;
      ea = (q0.size() == 0);
      eb = (q1.size() == 0);
      chk("R4", "dat_out", 32'(dat_out), 32'(e_line));
      chk("R9", "dat_oe", 32'(dat_oe), 32'(m_ph != 0));
      chk("R6", "empty_a", 32'(empty_a), 32'(ea));
      chk("R6", "empty_b", 32'(empty_b), 32'(eb));
      chk("R7", "irq", 32'(irq), 32'(xmit_sel && ((ea && !mask_a) || (eb && !mask_b))));
      chk("R8", "underrun", 32'(underrun), 32'(m_und));
      chk("R3", "overflow", 32'(overflow), 32'(m_ovf));
    end
  end

  task automatic write_bytes(int n, logic [7:0] first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = first + 8'(i);
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_oe_rise();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #2;
      if (dat_oe) return;
    end
    chk("R9", "frame start timeout", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic bits[90];
    logic [15:0] crc_seen;
    int dur;
    logic ea_keep, eb_keep;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", "reset empty_a", 32'(empty_a), 1);
    chk("R1", "reset empty_b", 32'(empty_b), 1);
    chk("R1", "reset line", 32'(dat_out), 1);
    chk("R1", "reset oe", 32'(dat_oe), 0);
    chk("R1", "reset status", 32'({underrun, overflow}), 0);

    @(negedge clk); xmit_sel = 1'b1; mask_a = 1'b1; mask_b = 1'b0; #2;
    chk("R7", "irq with b unmasked", 32'(irq), 1);
    mask_b = 1'b1; #1;
    chk("R7", "irq both masked", 32'(irq), 0);
    mask_a = 1'b0; mask_b = 1'b0;

    // Prefill: ASCII 1..9 then filler.
    write_bytes(8, 8'h31);
    #2;
    chk("R2", "A filled first", 32'({empty_b, empty_a}), 32'b10);
    write_bytes(1, 8'h39);
    write_bytes(7, 8'hA0);
    #2;
    chk("R2", "both filled", 32'({empty_b, empty_a}), 0);
    write_bytes(1, 8'hEE);
    #2;
    chk("R3", "overflow after 17th write", 32'(overflow), 1);

    // 9-byte frame: known CRC 0x31C3.
    blk_len = 10'd9;
    @(negedge clk); run_en = 1'b1;
    wait_oe_rise();
    run_en = 1'b0;
    bits[0] = dat_out;
    for (int k = 1; k < 90; k++) begin @(negedge clk); #2; bits[k] = dat_out; end
    chk("R4", "start bit", 32'(bits[0]), 0);
    for (int b = 0; b < 9; b++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[7-j] = bits[1 + b*8 + j];
      chk("R4", "payload byte", 32'(v), 32'(8'h31 + 8'(b)));
    end
    for (int j = 0; j < 16; j++) crc_seen[15-j] = bits[73 + j];
    chk("R4", "crc of 123456789", 32'(crc_seen), 32'h31C3);
    chk("R4", "end bit", 32'(bits[89]), 1);
    @(negedge clk); #2;
    chk("R5", "9-byte frame length", 32'(dat_oe), 0);
    chk("R6", "A drained, B holds rest", 32'({empty_b, empty_a}), 32'b01);

    // Run low: no new frame although B is full.
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #2;
      chk("R9", "no frame with run low", 32'(dat_oe), 0);
    end

    // Zero length sends one byte: 26 cycles.
    blk_len = '0;
    @(negedge clk); run_en = 1'b1;
    wait_oe_rise();
    run_en = 1'b0;
    dur = 0;
    while (dat_oe && dur < 200) begin dur++; @(negedge clk); #2; end
    chk("R5", "zero-length frame cycles", 32'(dur), 26);

    // Streaming 4-byte frames, refilling on empty flags, then starvation.
    blk_len = 10'd4;
    write_bytes(8, 8'h50);
    @(negedge clk); run_en = 1'b1;
    for (int i = 0; i < 1000 && !empty_b; i++) begin @(negedge clk); #2; end
    chk("R6", "B drains first", 32'(empty_b), 1);
    write_bytes(8, 8'h70);
    for (int i = 0; i < 2000 && !underrun; i++) begin @(negedge clk); #2; end
    chk("R8", "underrun set", 32'(underrun), 1);
    chk("R8", "line high in stall", 32'({dat_oe, dat_out}), 32'b11);
    repeat (5) @(negedge clk);
    #2;
    chk("R8", "still stalled", 32'({dat_oe, dat_out, underrun}), 32'b111);
    run_en = 1'b0;
    write_bytes(8, 8'h90);
    repeat (300) @(negedge clk);
    #2;
    chk("R9", "idle after run low", 32'(dat_oe), 0);
    chk("R8", "underrun sticky", 32'(underrun), 1);

    // Receive direction.
    ea_keep = empty_a; eb_keep = empty_b;
    @(negedge clk); xmit_sel = 1'b0;
    write_bytes(3, 8'hC0);
    #2;
    chk("R10", "status cleared", 32'({underrun, overflow}), 0);
    chk("R10", "line idle", 32'({dat_oe, dat_out}), 32'b01);
    chk("R10", "irq low", 32'(irq), 0);
    @(negedge clk); xmit_sel = 1'b1; #2;
    chk("R10", "fifo untouched", 32'({empty_b, empty_a}), 32'({eb_keep, ea_keep}));
    repeat (5) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule